// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block is a free-running timer/counter with two compare channels, called A (channel 0) and B (channel 1). The counter advances on clock edges where a prescaled tick enable is high. A 3-bit waveform-generation code picks how the counter runs and where its TOP lies. Each channel compares the counter against its own compare value and updates an output register according to a 2-bit compare-output mode. The actions are toggle, clear or set on a match, plus set or clear at TOP in the pulse-width modes. Phase-correct mode also takes the counting direction into account.

Each channel also reports whether it currently takes the pin away from ordinary port control. A pin-enable output combines that flag with a per-pin direction-enable input. Compare values are taken directly in the non-PWM modes. In the PWM modes they are held in a shadow register that loads once per period, so a new duty cycle never produces a glitched period.

Top module: `timer_wave_unit`

## Requirements
- R1: After reset the counter is 0, the counting direction is up and both waveform outputs are 0.
- R2: Bits [1:0] of `wgm` select the kind of operation: 00 normal, 01 phase-correct PWM, 10 clear-on-compare (CTC), 11 fast PWM. In normal, CTC and fast PWM the counter adds one on each tick and returns to 0 on the tick where it equals TOP.
- R3: In phase-correct PWM the counter counts up to TOP and then down to 0. The tick at TOP while counting up turns the direction down, and the tick at 0 while counting down turns it up. If TOP is 0, the counter stays at 0.
- R4: TOP is channel A's effective compare value in CTC, and also in both PWM kinds when `wgm[2]` is 1. Otherwise TOP is the all-ones counter value.
- R5: A channel's `ovr` bit is 1 only when its mode is nonzero, and it is 0 for the mode-01 cases that R8 and R10 call disconnected. `pin_oe` of a channel is `ovr` ANDed with that channel's `dir_en` bit.
- R6: In normal and CTC operation, on a tick where the counter equals the channel's compare value, mode 01 toggles the output, 10 clears it and 11 sets it. Mode 00 leaves the output unchanged.
- R7: In fast PWM, mode 10 clears the output on a match and sets it on the tick at TOP. Mode 11 sets it on a match and clears it at TOP. The TOP action wins when both occur on the same tick.
- R8: Channel B mode 01 in either PWM kind is reserved. The channel does not override the port, and its output register holds its value.
- R9: In phase-correct PWM, mode 10 clears the output on a match while counting up and sets it on a match while counting down. Mode 11 does the opposite.
- R10: Channel A mode 01 in a PWM kind toggles the output on a match when `wgm[2]` is 1. When `wgm[2]` is 0 the channel is disconnected, with `ovr` 0 and the output held.
- R11: In a PWM kind, when a channel's compare value equals TOP and its mode bit 1 is set, the match is ignored and the output is driven to the inverse of mode bit 0 on the tick at TOP.
- R12: In PWM kinds the compare values pass through shadow registers. These load from `cmp_a`/`cmp_b` only on the tick at TOP: the turning point in phase-correct, and the wrap to 0 in fast PWM. In non-PWM kinds the input values act at once.
- R13: The counter, the direction and both outputs change only on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| wgm | input | 3 | Waveform-generation code; bit 2 selects channel A as TOP |
| com_a | input | 2 | Compare-output mode of channel A |
| com_b | input | 2 | Compare-output mode of channel B |
| cmp_a | input | W | Compare value of channel A |
| cmp_b | input | W | Compare value of channel B |
| dir_en | input | 2 | Pin direction enables, bit 0 for A, bit 1 for B |
| count | output | W | Current counter value |
| wave | output | 2 | Output registers, bit 0 for A, bit 1 for B |
| ovr | output | 2 | Channel overrides normal port control |
| pin_oe | output | 2 | Pin driver enable per channel |

## Verification
The assertions check on every cycle that the counter, the direction and the outputs hold without a tick. They also check that the counter wraps at TOP and turns round in phase-correct mode. Further cycle checks cover the fast-PWM TOP action, the held output in the reserved and disconnected mode-01 cases, the ignored match when the compare value equals TOP, and the hold of the shadow compare registers between update points. Only the bench scenarios can show whole waveforms across mode changes. These include the exact duty cycle of each PWM kind, a shadowed TOP that keeps the old period after a new value is written, and a phase-correct output that stays set for many periods when its compare value equals TOP.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

   typedef enum logic [1:0] {
      WG_NORMAL = 2'b00,
      WG_PHASE  = 2'b01,
      WG_CTC    = 2'b10,
      WG_FAST   = 2'b11
   } wg_kind_e;

   localparam int unsigned NUM_CH = 2;

   function automatic logic kind_is_pwm(input wg_kind_e k);
      return (k == WG_PHASE) || (k == WG_FAST);
   endfunction

endpackage

// File: rtl/tcw_counter.sv
module tcw_counter
   import tcw_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  wg_kind_e     kind,
   input  logic [W-1:0] top,
   output logic [W-1:0] cnt,
   output logic         dir_up,
   output logic         at_top
);

   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   assign at_top = (cnt == top);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= ZERO;
         dir_up <= 1'b1;
      end else if (tick) begin
         if (kind == WG_PHASE) begin
            if (dir_up) begin
               if (at_top) begin
                  dir_up <= 1'b0;
                  cnt    <= (cnt == ZERO) ? ZERO : cnt - ONE;
               end else begin
                  cnt <= cnt + ONE;
               end
            end else begin
               if (cnt == ZERO) begin
                  dir_up <= 1'b1;
                  cnt    <= (top == ZERO) ? ZERO : ONE;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
         end else begin
            dir_up <= 1'b1;
            cnt    <= at_top ? ZERO : cnt + ONE;
         end
      end
   end

   p_hold_cnt_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(cnt) && $stable(dir_up)));

   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && kind != WG_PHASE && at_top) |=> (cnt == ZERO));

   p_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && kind == WG_PHASE && dir_up && at_top && cnt != ZERO) |=> !dir_up);

endmodule

// File: rtl/tcw_cmp_buf.sv
module tcw_cmp_buf #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         pwm,
   input  logic         upd,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] active
);

   logic [W-1:0] shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (!pwm || (tick && upd)) begin
         shadow_q <= d_in;
      end
   end

   assign active = pwm ? shadow_q : d_in;

   p_shadow_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm && !(tick && upd)) |=> $stable(shadow_q));

endmodule

// File: rtl/tcw_wave.sv
module tcw_wave
   import tcw_pkg::*;
#(
   parameter int unsigned W    = 8,
   parameter bit          IS_A = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  wg_kind_e     kind,
   input  logic         sel_top,
   input  logic [1:0]   com,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] cmp,
   input  logic [W-1:0] top,
   input  logic         at_top,
   input  logic         dir_up,
   output logic         wave,
   output logic         ovr
);

   logic live01;
   logic match;
   logic pwm;
   logic nxt;

   generate
      if (IS_A) begin : g_a
         assign live01 = sel_top;
      end else begin : g_b
         assign live01 = 1'b0;
      end
   endgenerate

   assign match = (cnt == cmp);
   assign pwm   = kind_is_pwm(kind);
   assign ovr   = (com != 2'b00) && !((com == 2'b01) && pwm && !live01);

   always_comb begin
      nxt = wave;
      case (kind)
         WG_NORMAL, WG_CTC: begin
            if (match) begin
               case (com)
                  2'b01:   nxt = ~wave;
                  2'b10:   nxt = 1'b0;
                  2'b11:   nxt = 1'b1;
                  default: nxt = wave;
               endcase
            end
         end
         WG_FAST: begin
            if (com[1]) begin
               if (at_top)     nxt = ~com[0];
               else if (match) nxt = com[0];
            end else if (com[0] && live01 && match) begin
               nxt = ~wave;
            end
         end
         default: begin
            if (com[1]) begin
               if (cmp == top) begin
                  if (at_top) nxt = ~com[0];
               end else if (match) begin
                  nxt = dir_up ? com[0] : ~com[0];
               end
            end else if (com[0] && live01 && match) begin
               nxt = ~wave;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    wave <= 1'b0;
      else if (tick) wave <= nxt;
   end

   p_wave_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(wave));

   p_fast_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && kind == WG_FAST && com[1] && at_top) |=> (wave == !$past(com[0])));

   p_mode01_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm && com == 2'b01 && !live01) |=> $stable(wave));

   p_top_match_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == WG_PHASE && com[1] && cmp == top && !at_top) |=> $stable(wave));

   p_ovr_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (com == 2'b00) |-> !ovr);

endmodule

// File: rtl/timer_wave_unit.sv
module timer_wave_unit
   import tcw_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [2:0]   wgm,
   input  logic [1:0]   com_a,
   input  logic [1:0]   com_b,
   input  logic [W-1:0] cmp_a,
   input  logic [W-1:0] cmp_b,
   input  logic [1:0]   dir_en,
   output logic [W-1:0] count,
   output logic [1:0]   wave,
   output logic [1:0]   ovr,
   output logic [1:0]   pin_oe
);

   localparam logic [W-1:0] MAXV = '1;

   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("timer_wave_unit: W must lie in 2..32");
      end
   endgenerate

   wg_kind_e     kind;
   logic         sel_top;
   logic         pwm;
   logic [W-1:0] top;
   logic         at_top;
   logic         dir_up;
   logic [W-1:0] cmp_in  [NUM_CH];
   logic [1:0]   com_in  [NUM_CH];
   logic [W-1:0] cmp_act [NUM_CH];

   assign kind      = wg_kind_e'(wgm[1:0]);
   assign sel_top   = wgm[2];
   assign pwm       = kind_is_pwm(kind);
   assign cmp_in[0] = cmp_a;
   assign cmp_in[1] = cmp_b;
   assign com_in[0] = com_a;
   assign com_in[1] = com_b;

   assign top = ((kind == WG_CTC) || (pwm && sel_top)) ? cmp_act[0] : MAXV;

   tcw_counter #(.W(W)) i_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .kind   (kind),
      .top    (top),
      .cnt    (count),
      .dir_up (dir_up),
      .at_top (at_top)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      tcw_cmp_buf #(.W(W)) i_buf (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .pwm    (pwm),
         .upd    (at_top),
         .d_in   (cmp_in[ch]),
         .active (cmp_act[ch])
      );

      tcw_wave #(.W(W), .IS_A(ch == 0)) i_wave (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .kind    (kind),
         .sel_top (sel_top),
         .com     (com_in[ch]),
         .cnt     (count),
         .cmp     (cmp_act[ch]),
         .top     (top),
         .at_top  (at_top),
         .dir_up  (dir_up),
         .wave    (wave[ch]),
         .ovr     (ovr[ch])
      );

      assign pin_oe[ch] = ovr[ch] & dir_en[ch];

      p_oe_needs_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !dir_en[ch] |-> !pin_oe[ch]);
   end

endmodule

// File: tb/test_timer_wave_unit.sv
`timescale 1ns/1ps
module test_timer_wave_unit;

   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic [2:0] wgm = 3'b000;
   logic [1:0] com_a = 2'b00, com_b = 2'b00;
   logic [W-1:0] cmp_a = '0, cmp_b = '0;
   logic [1:0] dir_en = 2'b00;
   logic [W-1:0] count;
   logic [1:0] wave, ovr, pin_oe;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   timer_wave_unit #(.W(W)) i_timer_wave_unit (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wgm(wgm), .com_a(com_a), .com_b(com_b),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .dir_en(dir_en), .count(count), .wave(wave),
      .ovr(ovr), .pin_oe(pin_oe));

   // reference model built from the requirements
   int m_cnt, m_dir;
   int m_buf[2];
   bit m_wave[2];

   function automatic bit is_pwm(input int k);
      return (k == 1) || (k == 3);
   endfunction

   function automatic bit exp_ovr(input int ch, input int k, input int sel, input int c);
      bit live = (ch == 0) && (sel == 1);
      if (c == 0) return 0;
      if (c == 1 && is_pwm(k) && !live) return 0;
      return 1;
   endfunction

   function automatic bit next_wave(input int ch, input bit w, input int k, input int sel,
                                    input int c, input int cnt, input int cv, input int top,
                                    input int dir);
      bit live = (ch == 0) && (sel == 1);
      bit m = (cnt == cv);
      bit c1 = c[1], c0 = c[0];
      if (k == 0 || k == 2) begin
         if (m) begin
            if (c == 1) return ~w;
            if (c == 2) return 0;
            if (c == 3) return 1;
         end
         return w;
      end
      if (c1) begin
         if (k == 3) begin
            if (cnt == top) return ~c0;
            if (m) return c0;
            return w;
         end
         if (cv == top) return (cnt == top) ? ~c0 : w;
         if (m) return dir ? c0 : ~c0;
         return w;
      end
      if (c0 && live && m) return ~w;
      return w;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_dir = 1; m_buf[0] = 0; m_buf[1] = 0; m_wave[0] = 0; m_wave[1] = 0;
      end else begin
         int k, top, ea, eb, nc, nd;
         bit pw, nw0, nw1;
         k = wgm[1:0];
         pw = is_pwm(k);
         ea = pw ? m_buf[0] : cmp_a;
         eb = pw ? m_buf[1] : cmp_b;
         top = (k == 2 || (pw && wgm[2])) ? ea : 255;
         nc = m_cnt; nd = m_dir; nw0 = m_wave[0]; nw1 = m_wave[1];
         if (tick) begin
            nw0 = next_wave(0, m_wave[0], k, wgm[2], com_a, m_cnt, ea, top, m_dir);
            nw1 = next_wave(1, m_wave[1], k, wgm[2], com_b, m_cnt, eb, top, m_dir);
            if (k == 1) begin
               if (m_dir) begin
                  if (m_cnt == top) begin nd = 0; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
                  else nc = (m_cnt + 1) % 256;
               end else begin
                  if (m_cnt == 0) begin nd = 1; nc = (top == 0) ? 0 : 1; end
                  else nc = m_cnt - 1;
               end
            end else begin
               nd = 1;
               nc = (m_cnt == top) ? 0 : (m_cnt + 1) % 256;
            end
         end
         if (!pw || (tick && m_cnt == top)) begin m_buf[0] = cmp_a; m_buf[1] = cmp_b; end
         m_cnt = nc; m_dir = nd; m_wave[0] = nw0; m_wave[1] = nw1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int k = wgm[1:0];
      int eo, eoe;
      string tc, tw;
      tc = (k == 1) ? "R3 count" : "R2 count";
      tw = (k == 3) ? "R7 wave" : (k == 1) ? "R9 wave" : "R6 wave";
      eo = {exp_ovr(1, k, wgm[2], com_b), exp_ovr(0, k, wgm[2], com_a)};
      eoe = eo & dir_en;
      chk(count == m_cnt, tc, count, m_cnt);
      chk(wave == {m_wave[1], m_wave[0]}, tw, wave, {m_wave[1], m_wave[0]});
      chk({pin_oe, ovr} == {eoe[1:0], eo[1:0]}, "R5 ovr/oe", {pin_oe, ovr}, {eoe[1:0], eo[1:0]});
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_all();
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; tick = 0; wgm = 0; com_a = 0; com_b = 0; cmp_a = 0; cmp_b = 0; dir_en = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int saved_c, saved_w;
      void'($urandom(32'd4711));
      do_reset();
      #1;
      chk(count == 0, "R1 count reset", count, 0);
      chk(wave == 0, "R1 wave reset", wave, 0);

      // R4 / R6: CTC with channel A as TOP
      wgm = 3'b010; cmp_a = 5; com_a = 2'b01; cmp_b = 2; com_b = 2'b11; dir_en = 2'b11; tick = 1;
      step(5);
      chk(count == 5, "R4 ctc at top", count, 5);
      chk(wave[0] == 0, "R6 toggle before match", wave[0], 0);
      step(1);
      chk(count == 0, "R4 ctc wrap", count, 0);
      chk(wave[0] == 1, "R6 toggle on match", wave[0], 1);
      chk(wave[1] == 1, "R6 set on match", wave[1], 1);

      // R13: no tick, nothing moves
      tick = 0; saved_c = count; saved_w = wave;
      step(10);
      chk(count == saved_c, "R13 count held", count, saved_c);
      chk(wave == saved_w, "R13 wave held", wave, saved_w);

      // R12: shadowed TOP in fast PWM
      do_reset();
      cmp_a = 20; step(1);
      wgm = 3'b111; tick = 1;
      step(10);
      cmp_a = 30;
      step(10);
      chk(count == 20, "R12 old top kept", count, 20);
      step(1);
      chk(count == 0, "R12 wrap at old top", count, 0);
      step(21);
      chk(count == 21, "R12 new top active", count, 21);

      // R10: channel A mode 01 in fast PWM
      do_reset();
      cmp_a = 4; step(1);
      wgm = 3'b111; com_a = 2'b01; tick = 1; dir_en = 2'b01;
      step(5);
      chk(ovr[0] == 1, "R10 override when top-select", ovr[0], 1);
      chk(wave[0] == 1, "R10 toggle on match", wave[0], 1);
      wgm = 3'b011; saved_w = wave[0];
      step(300);
      chk(ovr[0] == 0, "R10 disconnected", ovr[0], 0);
      chk(wave[0] == saved_w, "R10 output held", wave[0], saved_w);

      // R8: channel B mode 01 reserved in PWM
      do_reset();
      com_b = 2'b11; cmp_b = 0; tick = 1;
      step(2);
      wgm = 3'b011; com_b = 2'b01; dir_en = 2'b10;
      step(300);
      chk(ovr[1] == 0, "R8 no override", ovr[1], 0);
      chk(pin_oe[1] == 0, "R8 pin not driven", pin_oe[1], 0);
      chk(wave[1] == 1, "R8 output held", wave[1], 1);

      // R11: phase-correct, compare equal to TOP
      do_reset();
      cmp_b = 255; step(1);
      wgm = 3'b001; com_b = 2'b10; tick = 1;
      step(256);
      chk(wave[1] == 1, "R11 set at top", wave[1], 1);
      step(600);
      chk(wave[1] == 1, "R11 match ignored", wave[1], 1);

      // constrained random phases
      for (int ph = 0; ph < 50; ph++) begin
         wgm = $urandom % 8;
         com_a = $urandom % 4; com_b = $urandom % 4; dir_en = $urandom % 4;
         cmp_a = ($urandom % 3 == 0) ? $urandom % 16 : $urandom % 256;
         cmp_b = $urandom % 256;
         for (int c = 0; c < 300; c++) begin
            tick = ($urandom % 4) != 0;
            if (c % 37 == 36) begin
               cmp_a = ($urandom % 2) ? $urandom % 24 : $urandom % 256;
               cmp_b = $urandom % 256;
            end
            step(1);
         end
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule